// File: doc/BRIEF.md
# Interleaved Converter Phase Sequencer

This block generates the per-slice control strobes for a bank of sixteen successive-approximation converter slices that are interleaved in time and run from one shared input clock. Every slice executes the same sixteen-clock program without end: a reference-zero sample, an auto-zero comparison, a calibration comparison, an input sample, eleven bit-decision clocks, and a transfer of the finished word. The programs of neighbouring slices are staggered by one clock, so the input is taken by exactly one slice on every clock and one slice delivers a finished word on every clock.

A single wrap-around phase counter drives the whole bank. Each slice decodes its own local program step from that counter, offset by its slice number. The sequencer also reports the index of the slice that is transferring, for use as the select of the output word multiplexer. Analog sampling, comparator behaviour and the contents of the approximation registers belong to other blocks.

Top module: `ilv_phase_seq`

## Requirements
- R1: While `rst` is high at a rising edge, and in the clock that follows the last such edge, the phase counter is 0: slice 0 shows its reference-zero strobe, slice 13 shows its input-sample strobe and `mux_sel_o` is 1.
- R2: In every clock each slice asserts exactly one of its six strobes (reference zero, auto-zero, calibrate, input sample, bit decision, transfer).
- R3: A slice's program opens with reference zero on local clock 1, auto-zero on clock 2, calibrate on clock 3 and input sample on clock 4, each one clock after the previous.
- R4: On local clocks 5 to 15 a slice asserts its bit-decision strobe with `sar_bit_o` counting 10 on clock 5 down to 0 on clock 15; in every other clock the slice's `sar_bit_o` field reads 0.
- R5: Local clock 16 is the transfer clock, after which the slice returns to reference zero, giving a 16-clock period.
- R6: Slice k+1 (mod 16) runs the same program one clock behind slice k, so exactly one bit of `smp_o` is set in every clock.
- R7: `mux_sel_o` equals the index of the slice whose transfer strobe is set.
- R8: A slice's transfer strobe comes exactly 12 clocks after its input-sample strobe.
- R9: Raising `rst` in the middle of operation returns the sequencer to the R1 state at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all sequencing advances on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| refz_o | output | 16 | Per-slice reference-zero sample strobe |
| az_o | output | 16 | Per-slice auto-zero compare strobe |
| cal_o | output | 16 | Per-slice calibrate compare strobe |
| smp_o | output | 16 | Per-slice input-sample strobe |
| sar_o | output | 16 | Per-slice bit-decision enable |
| sar_bit_o | output | 16 x 4 | Per-slice bit index under decision, slice k in bits [4k+3:4k] |
| xfer_o | output | 16 | Per-slice word transfer strobe |
| mux_sel_o | output | 4 | Index of the slice currently transferring |

## Verification
The assertions assume only that the clock runs without gaps and that reset is synchronous; they are disabled while reset is high, and each step-to-step property treats a reset raised between two clocks as the start of a fresh program. The stimulus holds reset for several clocks at start-up, releases it, runs more than two full program periods, then raises reset for a single clock mid-program and runs again, so every program step of every slice, the wrap of the counter and a reset landing at an arbitrary phase are all covered.

// File: rtl/ilv_seq_pkg.sv
package ilv_seq_pkg;

    typedef struct packed {
        logic refz;
        logic az;
        logic cal;
        logic smp;
        logic sar;
        logic xfer;
    } strobe_t;

    localparam int SLOT_REFZ = 0;
    localparam int SLOT_AZ   = 1;
    localparam int SLOT_CAL  = 2;
    localparam int SLOT_SMP  = 3;
    localparam int SLOT_SAR0 = 4;

endpackage

// File: rtl/ilv_phase_ctr.sv
module ilv_phase_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.cnt = state_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o = state_q.cnt;

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (state_q.cnt == '1) |=> (state_q.cnt == '0)); // R5

endmodule

// File: rtl/ilv_slice_dec.sv
module ilv_slice_dec
    import ilv_seq_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int SLICE = 0,
    localparam int PROG_LEN = 1 << CNT_W,
    localparam int SAR_BITS = PROG_LEN - 5,
    localparam int BIT_W    = $clog2(SAR_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    output strobe_t          stb_o,
    output logic [BIT_W-1:0] bit_o
);

    localparam logic [CNT_W-1:0] OFS       = CNT_W'(SLICE);
    localparam logic [CNT_W-1:0] LAST_SAR  = CNT_W'(SLOT_SAR0 + SAR_BITS - 1);
    localparam logic [CNT_W-1:0] FIRST_SAR = CNT_W'(SLOT_SAR0);
    localparam logic [CNT_W-1:0] XFER_SLOT = CNT_W'(PROG_LEN - 1);

    logic [CNT_W-1:0] local_ph;
    logic [CNT_W-1:0] bit_wide;
    strobe_t          stb_d;
    logic [BIT_W-1:0] bit_d;

    always_comb begin
        local_ph = cnt_i - OFS;
        bit_wide = LAST_SAR - local_ph;
        stb_d    = '0;
        bit_d    = '0;
        if (local_ph == CNT_W'(SLOT_REFZ)) begin
            stb_d.refz = 1'b1;
        end else if (local_ph == CNT_W'(SLOT_AZ)) begin
            stb_d.az = 1'b1;
        end else if (local_ph == CNT_W'(SLOT_CAL)) begin
            stb_d.cal = 1'b1;
        end else if (local_ph == CNT_W'(SLOT_SMP)) begin
            stb_d.smp = 1'b1;
        end else if (local_ph >= FIRST_SAR && local_ph <= LAST_SAR) begin
            stb_d.sar = 1'b1;
            bit_d     = bit_wide[BIT_W-1:0];
        end else if (local_ph == XFER_SLOT) begin
            stb_d.xfer = 1'b1;
        end
    end

    assign stb_o = stb_d;
    assign bit_o = bit_d;

    AST_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
        $countones(stb_o) == 1); // R2
    AST_REFZ_TO_AZ: assert property (@(posedge clk) disable iff (rst)
        stb_o.refz |=> stb_o.az); // R3
    AST_AZ_TO_CAL: assert property (@(posedge clk) disable iff (rst)
        stb_o.az |=> stb_o.cal); // R3
    AST_CAL_TO_SMP: assert property (@(posedge clk) disable iff (rst)
        stb_o.cal |=> stb_o.smp); // R3
    AST_SMP_TO_MSB: assert property (@(posedge clk) disable iff (rst)
        stb_o.smp |=> (stb_o.sar && bit_o == BIT_W'(SAR_BITS - 1))); // R4
    AST_SAR_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (stb_o.sar && bit_o != '0) |=> (stb_o.sar && bit_o == BIT_W'($past(bit_o) - 1'b1))); // R4
    AST_IDLE_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !stb_o.sar |-> (bit_o == '0)); // R4
    AST_LSB_TO_XFER: assert property (@(posedge clk) disable iff (rst)
        (stb_o.sar && bit_o == '0) |=> stb_o.xfer); // R5
    AST_XFER_TO_REFZ: assert property (@(posedge clk) disable iff (rst)
        stb_o.xfer |=> stb_o.refz); // R5

endmodule

// File: rtl/ilv_onehot_enc.sv
module ilv_onehot_enc #(
    parameter int CNT_W = 4,
    localparam int N = 1 << CNT_W
) (
    input  logic [N-1:0]     hot_i,
    output logic [CNT_W-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (hot_i[i]) begin
                idx_o = idx_o | CNT_W'(i);
            end
        end
    end

endmodule

// File: rtl/ilv_phase_seq.sv
module ilv_phase_seq
    import ilv_seq_pkg::*;
#(
    parameter int CNT_W = 4,
    localparam int NSL   = 1 << CNT_W,
    localparam int BIT_W = $clog2(NSL - 5)
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic [NSL-1:0]             refz_o,
    output logic [NSL-1:0]             az_o,
    output logic [NSL-1:0]             cal_o,
    output logic [NSL-1:0]             smp_o,
    output logic [NSL-1:0]             sar_o,
    output logic [NSL-1:0][BIT_W-1:0]  sar_bit_o,
    output logic [NSL-1:0]             xfer_o,
    output logic [CNT_W-1:0]           mux_sel_o
);

    logic [CNT_W-1:0] cnt_q;
    strobe_t [NSL-1:0] stb;

    ilv_phase_ctr #(.CNT_W(CNT_W)) i_ctr (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt_q)
    );

    for (genvar k = 0; k < NSL; k++) begin : g_slice
        ilv_slice_dec #(.CNT_W(CNT_W), .SLICE(k)) i_dec (
            .clk   (clk),
            .rst   (rst),
            .cnt_i (cnt_q),
            .stb_o (stb[k]),
            .bit_o (sar_bit_o[k])
        );
        assign refz_o[k] = stb[k].refz;
        assign az_o[k]   = stb[k].az;
        assign cal_o[k]  = stb[k].cal;
        assign smp_o[k]  = stb[k].smp;
        assign sar_o[k]  = stb[k].sar;
        assign xfer_o[k] = stb[k].xfer;

        AST_SMP_HANDOFF: assert property (@(posedge clk) disable iff (rst)
            smp_o[k] |=> smp_o[(k + 1) % NSL]); // R6
    end

    ilv_onehot_enc #(.CNT_W(CNT_W)) i_enc (
        .hot_i (xfer_o),
        .idx_o (mux_sel_o)
    );

    AST_ONE_SAMPLER: assert property (@(posedge clk) disable iff (rst)
        $countones(smp_o) == 1); // R6
    AST_MUX_ON_XFER: assert property (@(posedge clk) disable iff (rst)
        xfer_o[mux_sel_o]); // R7

endmodule

// File: tb/test_ilv_phase_seq.sv
module test_ilv_phase_seq;

    localparam int NSL = 16;
    localparam int BW  = 4;

    typedef struct packed {
        logic [1:0]           mode;   // 0 run, 1 start-up reset, 2 mid-run reset
        logic [NSL-1:0]       refz, az, cal, smp, sar, xfer;
        logic [NSL-1:0][BW-1:0] bits;
        logic [3:0]           mux;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NSL-1:0] refz_o, az_o, cal_o, smp_o, sar_o, xfer_o;
    logic [NSL-1:0][BW-1:0] sar_bit_o;
    logic [3:0] mux_sel_o;

    int checks = 0;
    int failures = 0;
    int exp_cnt = 0;
    exp_t sb_q[$];
    bit done = 1'b0;

    always #4 clk = ~clk;

    ilv_phase_seq i_ilv_phase_seq (
        .clk       (clk),
        .rst       (rst),
        .refz_o    (refz_o),
        .az_o      (az_o),
        .cal_o     (cal_o),
        .smp_o     (smp_o),
        .sar_o     (sar_o),
        .sar_bit_o (sar_bit_o),
        .xfer_o    (xfer_o),
        .mux_sel_o (mux_sel_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic exp_t model(input int c, input logic [1:0] mode);
        exp_t e;
        e = '0;
        e.mode = mode;
        for (int k = 0; k < NSL; k++) begin
            int p;
            p = (c - k + NSL) % NSL;
            if (p == 0) e.refz[k] = 1'b1;
            else if (p == 1) e.az[k] = 1'b1;
            else if (p == 2) e.cal[k] = 1'b1;
            else if (p == 3) e.smp[k] = 1'b1;
            else if (p <= 14) begin
                e.sar[k]  = 1'b1;
                e.bits[k] = BW'(14 - p);
            end else e.xfer[k] = 1'b1;
        end
        e.mux = 4'((c + 1) % NSL);
        return e;
    endfunction

    // driver: one clock per call, pushes what the ports must show afterwards
    task automatic step(input logic r, input logic [1:0] mode);
        @(negedge clk);
        rst = r;
        @(posedge clk);
        #1;
        exp_cnt = r ? 0 : (exp_cnt + 1) % NSL;
        sb_q.push_back(model(exp_cnt, r ? mode : 2'd0));
    endtask

    // monitor
    initial begin
        int cyc = 0;
        int smp_at[NSL];
        bit smp_v[NSL];
        for (int k = 0; k < NSL; k++) smp_v[k] = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (sb_q.size() > 0) begin
                exp_t e;
                string tr3, tr4, tr5, tr6, tr7;
                e = sb_q.pop_front();
                tr3 = "R3"; tr4 = "R4"; tr5 = "R5"; tr6 = "R6"; tr7 = "R7";
                if (e.mode == 2'd1) begin tr3 = "R1"; tr4 = "R1"; tr5 = "R1"; tr6 = "R1"; tr7 = "R1"; end
                if (e.mode == 2'd2) begin tr3 = "R9"; tr4 = "R9"; tr5 = "R9"; tr6 = "R9"; tr7 = "R9"; end
                chk({tr3, " refz"}, 64'(refz_o), 64'(e.refz));
                chk({tr3, " az"},   64'(az_o),   64'(e.az));
                chk({tr3, " cal"},  64'(cal_o),  64'(e.cal));
                chk({tr6, " smp"},  64'(smp_o),  64'(e.smp));
                chk({tr4, " sar"},  64'(sar_o),  64'(e.sar));
                chk({tr4, " sar_bit"}, 64'(sar_bit_o), 64'(e.bits));
                chk({tr5, " xfer"}, 64'(xfer_o), 64'(e.xfer));
                chk({tr7, " mux_sel"}, 64'(mux_sel_o), 64'(e.mux));
                for (int k = 0; k < NSL; k++) begin
                    int n;
                    n = int'(refz_o[k]) + int'(az_o[k]) + int'(cal_o[k]) +
                        int'(smp_o[k]) + int'(sar_o[k]) + int'(xfer_o[k]);
                    chk("R2 one strobe per slice", 64'(n), 64'd1);
                end
                if (e.mode != 2'd0) begin
                    for (int k = 0; k < NSL; k++) smp_v[k] = 1'b0;
                end else begin
                    for (int k = 0; k < NSL; k++) begin
                        if (xfer_o[k] && smp_v[k]) begin
                            chk("R8 sample-to-transfer", 64'(cyc - smp_at[k]), 64'd12);
                            smp_v[k] = 1'b0;
                        end
                        if (smp_o[k]) begin
                            smp_at[k] = cyc;
                            smp_v[k]  = 1'b1;
                        end
                    end
                end
            end
        end
    end

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // watchdog
    initial begin
        #(8 * 20000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) step(1'b1, 2'd1);   // R1 start-up reset
        for (int i = 0; i < 40; i++) step(1'b0, 2'd0);
        step(1'b1, 2'd2);                               // R9 mid-run reset
        for (int i = 0; i < 50; i++) step(1'b0, 2'd0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        finish_up();
    end

endmodule